// File: doc/BRIEF.md
# Masked-ID Transaction Event Filter

This block watches three channels of a memory port that uses valid/ready handshakes: the read address channel, the write address channel and the read data channel. Each accepted handshake carries an ID. The block compares that ID with a programmed match value under a programmed mask. For every accepted transfer whose ID matches, it raises a one-cycle event strobe. There is one strobe per channel, and each has its own enable.

The three strobes are event sources for counters in a performance monitor. One strobe counts read requests from a chosen set of initiators, one counts write requests, and one counts read data beats. Software sets up the filter through a small register bus with two 32-bit registers. The first register holds the three enables and the mask. The second holds the match ID.

Top module: `axi_id_event_filter`

## Requirements
- R1: After a synchronous reset, all three event outputs are low, and both registers read back as zero.
- R2: The control register sits at offset 0x00. Bit 31 enables read-request events, bit 30 enables write-request events and bit 29 enables read-beat events. Bits 17:0 hold the mask. All other bits read as zero.
- R3: The match register sits at offset 0x04. Bits 17:0 hold the match ID, and bits 31:18 read as zero.
- R4: A write to any other offset changes neither register, and a read from any other offset returns zero.
- R5: An ID matches when (id AND mask) equals (match ID AND mask). An all-zero mask therefore matches every ID, and a mask bit that is set makes that ID bit count, including bit 17 and bit 0.
- R6: A read-address handshake (valid and ready both high) with a matching ID, while bit 31 is set, gives a one-cycle pulse on `evt_rd_txn` in the cycle after the handshake.
- R7: A write-address handshake with a matching ID, while bit 30 is set, gives a one-cycle pulse on `evt_wr_txn` in the cycle after the handshake.
- R8: Every accepted read data beat with a matching ID, while bit 29 is set, gives a pulse on `evt_rd_beat` in the following cycle. Beats on back-to-back cycles give back-to-back pulses.
- R9: A valid without ready, or a ready without valid, never raises an event.
- R10: While an enable bit is clear, its event output stays low, even for matching handshakes.
- R11: A register write governs handshakes from the next cycle onwards. A handshake in the same cycle as the write is judged by the old settings. Writing one enable bit leaves the channels that keep their enable unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 18 | Read address ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 18 | Write address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | 18 | Read data ID |
| evt_rd_txn | output | 1 | Filtered read-request event pulse |
| evt_wr_txn | output | 1 | Filtered write-request event pulse |
| evt_rd_beat | output | 1 | Filtered read-beat event pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit register offset and the fixed 18-bit ID width.

The full 18-bit ID lets the bench place mask bits at both extreme positions, bit 17 and bit 0, and in a middle nibble. The 8-bit offset space leaves room to probe unmapped offsets such as 0x08 and 0xFC next to the two real registers.

The bench also aims writes at the same cycle as a handshake, to pin down the moment a new setting takes effect.

// File: rtl/idf_pkg.sv
package idf_pkg;

    localparam int ID_W       = 18;
    localparam int REG_DW     = 32;
    localparam int NUM_CHAN   = 3;
    localparam int EN_RD_BIT  = 31;
    localparam int EN_WR_BIT  = 30;
    localparam int EN_BT_BIT  = 29;
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_MATCH  = 'h04;

    typedef enum logic [1:0] {
        CH_RD_TXN  = 2'd0,
        CH_WR_TXN  = 2'd1,
        CH_RD_BEAT = 2'd2
    } chan_e;

    typedef struct packed {
        logic            en_rd;
        logic            en_wr;
        logic            en_beat;
        logic [ID_W-1:0] mask;
        logic [ID_W-1:0] match_id;
    } filt_cfg_t;

    function automatic logic id_hit(input logic [ID_W-1:0] id,
                                    input logic [ID_W-1:0] ref_id,
                                    input logic [ID_W-1:0] mask);
        return ((id ^ ref_id) & mask) == '0;
    endfunction

    function automatic logic [NUM_CHAN-1:0] en_vec(input filt_cfg_t c);
        logic [NUM_CHAN-1:0] v;
        v[CH_RD_TXN]  = c.en_rd;
        v[CH_WR_TXN]  = c.en_wr;
        v[CH_RD_BEAT] = c.en_beat;
        return v;
    endfunction

endpackage

// File: rtl/idf_cfg_regs.sv
module idf_cfg_regs
    import idf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output filt_cfg_t         cfg
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);

    logic sel_ctrl;
    logic sel_match;

    assign sel_ctrl  = (reg_addr == A_CTRL);
    assign sel_match = (reg_addr == A_MATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_we) begin
            if (sel_ctrl) begin
                cfg.en_rd   <= reg_wdata[EN_RD_BIT];
                cfg.en_wr   <= reg_wdata[EN_WR_BIT];
                cfg.en_beat <= reg_wdata[EN_BT_BIT];
                cfg.mask    <= reg_wdata[ID_W-1:0];
            end
            if (sel_match) begin
                cfg.match_id <= reg_wdata[ID_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[EN_RD_BIT] = cfg.en_rd;
            reg_rdata[EN_WR_BIT] = cfg.en_wr;
            reg_rdata[EN_BT_BIT] = cfg.en_beat;
            reg_rdata[ID_W-1:0]  = cfg.mask;
        end else if (sel_match) begin
            reg_rdata[ID_W-1:0]  = cfg.match_id;
        end
    end

    // R4: stray writes leave every setting alone
    a_r4_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != A_CTRL && reg_addr != A_MATCH) |=> $stable(cfg));

    // R2: a control write lands in the mask on the next cycle
    a_r2_ctrl_mask_written: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_CTRL) |=> (cfg.mask == $past(reg_wdata[ID_W-1:0])));

    // R3: upper bits of the match register never read as one
    a_r3_match_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_MATCH) |-> (reg_rdata[REG_DW-1:ID_W] == '0));

endmodule

// File: rtl/idf_event_chan.sv
module idf_event_chan
    import idf_pkg::*;
#(
    parameter chan_e KIND = CH_RD_TXN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            ready,
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] match_id,
    input  logic [ID_W-1:0] mask,
    input  logic            enable,
    output logic            pulse
);

    logic fire;

    assign fire = enable && valid && ready && id_hit(id, match_id, mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end

    // R9: a pulse always stems from a completed handshake
    a_r9_pulse_needs_handshake: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(valid && ready));

    // R10: a cleared enable in the prior cycle means silence
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !pulse);

endmodule

// File: rtl/axi_id_event_filter.sv
module axi_id_event_filter
    import idf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [17:0]       ar_id,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [17:0]       aw_id,
    input  logic              r_valid,
    input  logic              r_ready,
    input  logic [17:0]       r_id,
    output logic              evt_rd_txn,
    output logic              evt_wr_txn,
    output logic              evt_rd_beat
);

    filt_cfg_t           cfg;
    logic [NUM_CHAN-1:0] ch_valid;
    logic [NUM_CHAN-1:0] ch_ready;
    logic [NUM_CHAN-1:0] ch_en;
    logic [NUM_CHAN-1:0] ch_pulse;
    logic [ID_W-1:0]     ch_id [NUM_CHAN];

    idf_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    assign ch_valid = {r_valid, aw_valid, ar_valid};
    assign ch_ready = {r_ready, aw_ready, ar_ready};
    assign ch_id[CH_RD_TXN]  = ar_id;
    assign ch_id[CH_WR_TXN]  = aw_id;
    assign ch_id[CH_RD_BEAT] = r_id;
    assign ch_en = en_vec(cfg);

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        idf_event_chan #(.KIND(chan_e'(g))) u_chan (
            .clk      (clk),
            .rst      (rst),
            .valid    (ch_valid[g]),
            .ready    (ch_ready[g]),
            .id       (ch_id[g]),
            .match_id (cfg.match_id),
            .mask     (cfg.mask),
            .enable   (ch_en[g]),
            .pulse    (ch_pulse[g])
        );
    end

    assign evt_rd_txn  = ch_pulse[CH_RD_TXN];
    assign evt_wr_txn  = ch_pulse[CH_WR_TXN];
    assign evt_rd_beat = ch_pulse[CH_RD_BEAT];

    // R6: read request pulse follows an accepted, matching read address
    a_r6_rd_txn_source: assert property (@(posedge clk) disable iff (rst)
        evt_rd_txn |-> $past(ar_valid && ar_ready && cfg.en_rd));

    // R7: write request pulse follows an accepted write address
    a_r7_wr_txn_source: assert property (@(posedge clk) disable iff (rst)
        evt_wr_txn |-> $past(aw_valid && aw_ready && cfg.en_wr));

    // R8: beat pulse follows an accepted read data beat
    a_r8_beat_source: assert property (@(posedge clk) disable iff (rst)
        evt_rd_beat |-> $past(r_valid && r_ready && cfg.en_beat));

    // R5: the ID behind a read pulse agreed on every masked bit
    a_r5_masked_agree: assert property (@(posedge clk) disable iff (rst)
        evt_rd_txn |-> ((($past(ar_id) ^ $past(cfg.match_id)) & $past(cfg.mask)) == '0));

endmodule

// File: tb/tb_axi_id_event_filter.sv
`timescale 1ns/1ps
module tb_axi_id_event_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0, r_valid = 0, r_ready = 0;
    logic [17:0] ar_id = '0, aw_id = '0, r_id = '0;
    logic        evt_rd_txn, evt_wr_txn, evt_rd_beat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic [2:0] ev;   // {beat, wr, rd}
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model of the settings
    logic        m_rd = 0, m_wr = 0, m_bt = 0;
    logic [17:0] m_mask = '0, m_id = '0;

    always #2.5 clk = ~clk;

    axi_id_event_filter dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
        .evt_rd_txn(evt_rd_txn), .evt_wr_txn(evt_wr_txn), .evt_rd_beat(evt_rd_beat)
    );

    function automatic logic hit(input logic [17:0] id);
        for (int b = 0; b < 18; b++)
            if (m_mask[b] && (id[b] != m_id[b])) return 1'b0;
        return 1'b1;
    endfunction

    // monitor: pops one expectation per cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if ({evt_rd_beat, evt_wr_txn, evt_rd_txn} !== e.ev) begin
                n_fail++;
                $display("FAIL %s events actual=%b expected=%b", e.tag,
                         {evt_rd_beat, evt_wr_txn, evt_rd_txn}, e.ev);
            end
        end
    end

    task automatic step(input logic arv, arr, input logic [17:0] arid,
                        input logic awv, awr, input logic [17:0] awid,
                        input logic rv, rr, input logic [17:0] rid,
                        input logic we, input logic [7:0] addr,
                        input logic [31:0] wd, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        ar_valid = arv; ar_ready = arr; ar_id = arid;
        aw_valid = awv; aw_ready = awr; aw_id = awid;
        r_valid = rv;   r_ready = rr;   r_id = rid;
        reg_we = we; reg_addr = addr; reg_wdata = wd;
        e.tag = tag;
        e.ev[0] = m_rd && arv && arr && hit(arid);
        e.ev[1] = m_wr && awv && awr && hit(awid);
        e.ev[2] = m_bt && rv && rr && hit(rid);
        exp_q.push_back(e);
        if (we && addr == 8'h00) begin
            m_rd = wd[31]; m_wr = wd[30]; m_bt = wd[29]; m_mask = wd[17:0];
        end else if (we && addr == 8'h04) begin
            m_id = wd[17:0];
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(0,0,'0, 0,0,'0, 0,0,'0, 1'b1, a, d, tag);
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] expv, input string tag);
        step(0,0,'0, 0,0,'0, 0,0,'0, 1'b0, a, '0, tag);
        #1;
        n_checks++;
        if (reg_rdata !== expv) begin
            n_fail++;
            $display("FAIL %s rdata@%h actual=%h expected=%h", tag, a, reg_rdata, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #1 rst = 1'b0;
        // R1: reset state
        n_checks++;
        if ({evt_rd_beat, evt_wr_txn, evt_rd_txn} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1 events actual=%b expected=000", {evt_rd_beat, evt_wr_txn, evt_rd_txn});
        end
        rd_check(8'h00, 32'h0, "R1");
        rd_check(8'h04, 32'h0, "R1");

        // R2, R3: layout and read-back
        wr(8'h00, 32'hFFFF_FFFF, "R2");
        rd_check(8'h00, 32'hE003_FFFF, "R2");
        wr(8'h04, 32'hFFFF_FFFF, "R3");
        rd_check(8'h04, 32'h0003_FFFF, "R3");

        // R4: unmapped offsets
        wr(8'h08, 32'h1234_5678, "R4");
        wr(8'hFC, 32'h0000_0000, "R4");
        rd_check(8'h08, 32'h0, "R4");
        rd_check(8'h00, 32'hE003_FFFF, "R4");
        rd_check(8'h04, 32'h0003_FFFF, "R4");

        // only read requests enabled, full mask
        wr(8'h00, 32'h8003_FFFF, "R10");
        wr(8'h04, 32'h0002_A5A5, "R10");
        step(1,1,18'h2A5A5, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R6");
        step(1,1,18'h2A5A4, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R5");
        step(1,0,18'h2A5A5, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R9");
        step(0,1,18'h2A5A5, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R9");
        step(0,0,'0, 1,1,18'h2A5A5, 1,1,18'h2A5A5, 0,8'h00,'0, "R10");
        step(0,0,'0, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R10");

        // all enabled, middle-nibble mask
        wr(8'h00, 32'hE000_0F00, "R5");
        wr(8'h04, 32'h0000_0300, "R5");
        step(1,1,18'h3F3FF, 1,1,18'h00400, 0,0,'0, 0,8'h00,'0, "R7");
        step(0,0,'0, 1,1,18'h1F3AB, 1,1,18'h00300, 0,8'h00,'0, "R7");
        step(0,0,'0, 0,0,'0, 1,1,18'h1F3AB, 0,8'h00,'0, "R8");
        step(0,0,'0, 0,0,'0, 1,1,18'h00200, 0,8'h00,'0, "R8");
        step(0,0,'0, 0,0,'0, 1,1,18'h00300, 0,8'h00,'0, "R8");
        step(0,0,'0, 0,0,'0, 1,0,18'h00300, 0,8'h00,'0, "R9");
        step(1,1,18'h00300, 1,1,18'h00300, 1,1,18'h00300, 0,8'h00,'0, "R6");

        // zero mask matches anything
        wr(8'h00, 32'hE000_0000, "R5");
        step(1,1,18'h15555, 1,1,18'h2AAAA, 1,1,18'h00001, 0,8'h00,'0, "R5");

        // extreme bits of the mask
        wr(8'h00, 32'hE002_0001, "R5");
        wr(8'h04, 32'h0002_0001, "R5");
        step(1,1,18'h3FFFF, 1,1,18'h00001, 1,1,18'h20000, 0,8'h00,'0, "R5");
        step(1,1,18'h20001, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R5");

        // R11: clear only write enable; handshakes beside the write use old settings
        step(1,1,18'h20001, 1,1,18'h20001, 1,1,18'h20001, 1,8'h00,32'hA002_0001, "R11");
        step(1,1,18'h20001, 1,1,18'h20001, 1,1,18'h20001, 0,8'h00,'0, "R11");
        rd_check(8'h00, 32'hA002_0001, "R11");
        step(1,1,'0, 0,0,'0, 0,0,'0, 1,8'h04,32'h0000_0000, "R11");
        step(1,1,'0, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R11");

        // R10: all disabled
        wr(8'h00, 32'h0000_0000, "R10");
        step(1,1,18'h00000, 1,1,18'h00000, 1,1,18'h00000, 0,8'h00,'0, "R10");
        step(0,0,'0, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R10");
        step(0,0,'0, 0,0,'0, 0,0,'0, 0,8'h00,'0, "R10");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule